// File: doc/BRIEF.md
# Strap-Latched Clock Mode Divider

This block fixes the clock mode of a clock generator once, at power-up, and then derives the output clock rates for that mode. It watches an active-low power-good strobe. The first time the strobe is seen low, it captures a three-level mode strap and a binary frequency strap. After that, neither the straps nor the strobe have any effect until the next reset. The three-level strap is presented as a 2-bit code.

Every source clock is modelled as a one-cycle tick enable in the block's single clock domain. The sources are an internal high-rate oscillator, an external 66 MHz input, a test clock, the crystal reference and a 48 MHz source. For each output group, the latched mode picks a source and a division ratio. Each group output is a registered one-cycle enable that pulses once per divided period.

There are three modes. In normal mode, everything except the reference and 48 MHz groups comes from the internal oscillator. In buffered mode, the 66 MHz buffer group and the PCI group come from the external 66 MHz input. In test mode, every group comes from the test clock. All dividers restart together at the capture, so groups that share a source are phase-aligned. Combinations that select no mode hold every group low and raise an error flag.

Top module: `strap_clk_divider`

## Requirements
- R1: After reset and before the strobe is first seen low, `strap_valid` is 0 and every group enable stays 0, even while source ticks are present.
- R2: On the first clock edge at which `pwrgd_n` is 0, `mode_code` and `freq_sel` are captured into `strap_mode`/`strap_freq`, and `strap_valid` goes to 1. All are visible right after that edge.
- R3: Once captured, later changes on `mode_code`, `freq_sel` or `pwrgd_n` do not alter the captured straps or the group rates.
- R4: Normal mode (code 00), `freq_sel`=0, uses the internal tick. CPU is divided by 4, 3V66 and 66-buffer by 6, and PCI by 12.
- R5: With `freq_sel`=1, in normal or buffered mode, the CPU group divides the internal tick by 3 instead of 4.
- R6: Buffered mode (code 10) passes the external 66 MHz tick straight to the 66-buffer group and divides it by 2 for the PCI group. The 3V66 group stays on the internal tick divided by 6.
- R7: Test mode (code 01, `freq_sel`=0) takes every group from the test tick. CPU is divided by 2, 3V66 and 66-buffer by 4, PCI by 8, REF by 1 and 48 MHz by 2.
- R8: Code 01 with `freq_sel`=1, and code 11, are reserved. In these modes `mode_error` is 1 and every group enable stays 0.
- R9: Dividers restart at the capture. The first pulse of a divide-by-N group appears after the Nth source tick that follows the capture edge. On a shared source, every PCI pulse coincides with a 3V66 pulse.
- R10: In normal and buffered modes, the REF group follows the crystal tick and the 48 MHz group follows its source tick, each one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_code | input | 2 | Three-level mode strap: 00 low, 01 mid, 10 high, 11 reserved |
| freq_sel | input | 1 | CPU frequency strap: 0 = 100 MHz ratio, 1 = 133 MHz ratio |
| pwrgd_n | input | 1 | Active-low power-good strobe |
| vco_tick | input | 1 | Internal oscillator tick |
| ext66_tick | input | 1 | External 66 MHz input tick |
| tclk_tick | input | 1 | Test clock tick |
| xtal_tick | input | 1 | Crystal reference tick |
| usb_src_tick | input | 1 | 48 MHz source tick |
| cpu_en | output | 1 | CPU group enable |
| v66_en | output | 1 | 3V66 group enable |
| buf66_en | output | 1 | 66 MHz buffer group enable |
| pci_en | output | 1 | PCI group enable |
| ref_en | output | 1 | Reference group enable |
| usb_en | output | 1 | 48 MHz group enable |
| strap_mode | output | 2 | Captured mode code |
| strap_freq | output | 1 | Captured frequency strap |
| strap_valid | output | 1 | Straps have been captured |
| mode_error | output | 1 | Captured straps select a reserved mode |

## Verification
The captured straps, `strap_valid` and `mode_error` are due right after the edge that samples the strobe low, so the bench checks them at the falling edge that follows. Each group enable is registered once. A tick sampled at an edge therefore shows its pulse right after that same edge. A divide-by-N group first pulses after the Nth tick edge following the capture.

The bench holds its ticks across a fixed window of 24 edges. It samples at each falling edge, counts the pulses per group, and records the sample index of the first CPU and PCI pulse. The expected values are 24/N counts and an index of N-1.

// File: rtl/strap_clk_pkg.sv
package strap_clk_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_EXT66  = 2'd1,
    MODE_TEST   = 2'd2,
    MODE_RSVD   = 2'd3
  } clk_mode_t;

  localparam int NGRP    = 6;
  localparam int G_CPU   = 0;
  localparam int G_V66   = 1;
  localparam int G_BUF66 = 2;
  localparam int G_PCI   = 3;
  localparam int G_REF   = 4;
  localparam int G_USB   = 5;

  function automatic clk_mode_t decode_mode(input logic [1:0] code, input logic fsel);
    case (code)
      2'b00:   return MODE_NORMAL;
      2'b10:   return MODE_EXT66;
      2'b01:   return fsel ? MODE_RSVD : MODE_TEST;
      default: return MODE_RSVD;
    endcase
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_code,
  input  logic       freq_sel,
  input  logic       pwrgd_n,
  output logic       capture,
  output logic [1:0] held_mode,
  output logic       held_freq,
  output logic       valid
);
  assign capture = !valid && !pwrgd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid     <= 1'b0;
      held_mode <= 2'b00;
      held_freq <= 1'b0;
    end else if (capture) begin
      valid     <= 1'b1;
      held_mode <= mode_code;
      held_freq <= freq_sel;
    end
  end

  // R3: captured straps never move while valid stays set
  a_r3_strap_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(valid)) |-> ($stable(held_mode) && $stable(held_freq)));
  // R2: a low strobe while not yet valid always yields valid next cycle
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (!valid && !pwrgd_n) |=> valid);
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] div,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last = (cnt == div - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (run && tick) begin
        if (last) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R9: the phase counter stays inside the divide window
  a_r9_cnt_range: assert property (@(posedge clk) disable iff (rst)
    (div != '0) |-> (cnt < div));
endmodule

// File: rtl/strap_clk_divider.sv
module strap_clk_divider #(
  parameter int CNT_W       = 4,
  parameter int CPU_DIV_LO  = 4,
  parameter int CPU_DIV_HI  = 3,
  parameter int V66_DIV     = 6,
  parameter int PCI_DIV     = 12,
  parameter int EXT_PCI_DIV = 2,
  parameter int T_CPU_DIV   = 2,
  parameter int T_V66_DIV   = 4,
  parameter int T_PCI_DIV   = 8,
  parameter int T_USB_DIV   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_code,
  input  logic       freq_sel,
  input  logic       pwrgd_n,
  input  logic       vco_tick,
  input  logic       ext66_tick,
  input  logic       tclk_tick,
  input  logic       xtal_tick,
  input  logic       usb_src_tick,
  output logic       cpu_en,
  output logic       v66_en,
  output logic       buf66_en,
  output logic       pci_en,
  output logic       ref_en,
  output logic       usb_en,
  output logic [1:0] strap_mode,
  output logic       strap_freq,
  output logic       strap_valid,
  output logic       mode_error
);
  import strap_clk_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             capture;
  logic             run;
  clk_mode_t        mode;
  logic             grp_tick  [NGRP];
  logic [CNT_W-1:0] grp_div   [NGRP];
  logic [NGRP-1:0]  grp_pulse;

  strap_capture u_capture (
    .clk      (clk),
    .rst      (rst),
    .mode_code(mode_code),
    .freq_sel (freq_sel),
    .pwrgd_n  (pwrgd_n),
    .capture  (capture),
    .held_mode(strap_mode),
    .held_freq(strap_freq),
    .valid    (strap_valid)
  );

  assign mode       = decode_mode(strap_mode, strap_freq);
  assign mode_error = strap_valid && (mode == MODE_RSVD);
  assign run        = strap_valid && (mode != MODE_RSVD);

  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      grp_tick[g] = 1'b0;
      grp_div[g]  = ONE;
    end
    case (mode)
      MODE_NORMAL, MODE_EXT66: begin
        grp_tick[G_CPU] = vco_tick;
        grp_div[G_CPU]  = strap_freq ? CNT_W'(CPU_DIV_HI) : CNT_W'(CPU_DIV_LO);
        grp_tick[G_V66] = vco_tick;
        grp_div[G_V66]  = CNT_W'(V66_DIV);
        grp_tick[G_REF] = xtal_tick;
        grp_tick[G_USB] = usb_src_tick;
        if (mode == MODE_NORMAL) begin
          grp_tick[G_BUF66] = vco_tick;
          grp_div[G_BUF66]  = CNT_W'(V66_DIV);
          grp_tick[G_PCI]   = vco_tick;
          grp_div[G_PCI]    = CNT_W'(PCI_DIV);
        end else begin
          grp_tick[G_BUF66] = ext66_tick;
          grp_tick[G_PCI]   = ext66_tick;
          grp_div[G_PCI]    = CNT_W'(EXT_PCI_DIV);
        end
      end
      MODE_TEST: begin
        for (int g = 0; g < NGRP; g++) grp_tick[g] = tclk_tick;
        grp_div[G_CPU]   = CNT_W'(T_CPU_DIV);
        grp_div[G_V66]   = CNT_W'(T_V66_DIV);
        grp_div[G_BUF66] = CNT_W'(T_V66_DIV);
        grp_div[G_PCI]   = CNT_W'(T_PCI_DIV);
        grp_div[G_USB]   = CNT_W'(T_USB_DIV);
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    tick_divider #(.CNT_W(CNT_W)) u_div (
      .clk  (clk),
      .rst  (rst),
      .clear(capture),
      .run  (run),
      .tick (grp_tick[g]),
      .div  (grp_div[g]),
      .pulse(grp_pulse[g])
    );
  end

  assign cpu_en   = grp_pulse[G_CPU];
  assign v66_en   = grp_pulse[G_V66];
  assign buf66_en = grp_pulse[G_BUF66];
  assign pci_en   = grp_pulse[G_PCI];
  assign ref_en   = grp_pulse[G_REF];
  assign usb_en   = grp_pulse[G_USB];

  // R1: nothing toggles before the straps are captured
  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    !strap_valid |-> (grp_pulse == '0));
  // R8: reserved modes keep all groups quiet
  a_r8_rsvd_quiet: assert property (@(posedge clk) disable iff (rst)
    mode_error |-> (grp_pulse == '0));
  // R9: PCI pulses align with 3V66 pulses on a shared source
  a_r9_aligned: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_NORMAL || mode == MODE_TEST) && pci_en) |-> v66_en);
  // R3: the decoded mode is frozen after capture
  a_r3_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    (strap_valid && $past(strap_valid)) |-> $stable(mode_error));
endmodule

// File: tb/test_strap_clk_divider.sv
module test_strap_clk_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_code = 2'b00;
  logic       freq_sel = 1'b0;
  logic       pwrgd_n = 1'b1;
  logic       vco_tick = 1'b0, ext66_tick = 1'b0, tclk_tick = 1'b0;
  logic       xtal_tick = 1'b0, usb_src_tick = 1'b0;
  logic       cpu_en, v66_en, buf66_en, pci_en, ref_en, usb_en;
  logic [1:0] strap_mode;
  logic       strap_freq, strap_valid, mode_error;

  int checks = 0;
  int errors = 0;
  int n_cpu, n_v66, n_buf, n_pci, n_ref, n_usb, first_cpu, first_pci;

  always #10 clk = ~clk;

  strap_clk_divider i_strap_clk_divider (
    .clk(clk), .rst(rst), .mode_code(mode_code), .freq_sel(freq_sel),
    .pwrgd_n(pwrgd_n), .vco_tick(vco_tick), .ext66_tick(ext66_tick),
    .tclk_tick(tclk_tick), .xtal_tick(xtal_tick), .usb_src_tick(usb_src_tick),
    .cpu_en(cpu_en), .v66_en(v66_en), .buf66_en(buf66_en), .pci_en(pci_en),
    .ref_en(ref_en), .usb_en(usb_en), .strap_mode(strap_mode),
    .strap_freq(strap_freq), .strap_valid(strap_valid), .mode_error(mode_error)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic set_ticks(input logic v, input logic e, input logic t,
                           input logic x, input logic u);
    vco_tick = v; ext66_tick = e; tclk_tick = t; xtal_tick = x; usb_src_tick = u;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pwrgd_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // strobe low for one edge; returns at the falling edge after capture
  task automatic power_up(input logic [1:0] code, input logic fs);
    do_reset();
    mode_code = code; freq_sel = fs; pwrgd_n = 1'b0;
    @(negedge clk);
  endtask

  // 24 edges; optional alternating external tick
  task automatic window(input bit ext_alt);
    n_cpu = 0; n_v66 = 0; n_buf = 0; n_pci = 0; n_ref = 0; n_usb = 0;
    first_cpu = -1; first_pci = -1;
    if (ext_alt) ext66_tick = 1'b1;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      n_cpu += int'(cpu_en); n_v66 += int'(v66_en); n_buf += int'(buf66_en);
      n_pci += int'(pci_en); n_ref += int'(ref_en); n_usb += int'(usb_en);
      if (cpu_en && first_cpu < 0) first_cpu = k;
      if (pci_en && first_pci < 0) first_pci = k;
      if (ext_alt) ext66_tick = ((k + 1) % 2 == 0);
    end
  endtask

  task automatic t_idle();
    do_reset();
    set_ticks(1, 1, 1, 1, 1);
    check("R1 strap_valid after reset", strap_valid, 0);
    window(0);
    check("R1 pulses before strobe", n_cpu + n_v66 + n_buf + n_pci + n_ref + n_usb, 0);
    check("R1 strap_valid held low", strap_valid, 0);
  endtask

  task automatic t_normal_100();
    set_ticks(1, 0, 0, 1, 1);
    power_up(2'b00, 1'b0);
    check("R2 strap_valid", strap_valid, 1);
    check("R2 strap_mode", strap_mode, 0);
    check("R2 strap_freq", strap_freq, 0);
    check("R8 no error in normal", mode_error, 0);
    window(0);
    check("R4 cpu /4", n_cpu, 6);
    check("R4 v66 /6", n_v66, 4);
    check("R4 buf66 /6", n_buf, 4);
    check("R4 pci /12", n_pci, 2);
    check("R9 first cpu index", first_cpu, 3);
    check("R9 first pci index", first_pci, 11);
    check("R10 ref follows crystal", n_ref, 24);
    check("R10 usb follows source", n_usb, 24);
  endtask

  task automatic t_normal_133();
    set_ticks(1, 0, 0, 1, 0);
    power_up(2'b00, 1'b1);
    check("R2 strap_freq high", strap_freq, 1);
    window(0);
    check("R5 cpu /3", n_cpu, 8);
    check("R9 first cpu index /3", first_cpu, 2);
    check("R10 usb idle without source", n_usb, 0);
  endtask

  task automatic t_ignore();
    set_ticks(1, 0, 0, 0, 0);
    power_up(2'b00, 1'b0);
    mode_code = 2'b01; freq_sel = 1'b1; pwrgd_n = 1'b1;
    @(negedge clk);
    pwrgd_n = 1'b0;
    @(negedge clk);
    check("R3 strap_mode kept", strap_mode, 0);
    check("R3 strap_freq kept", strap_freq, 0);
    check("R3 no error after change", mode_error, 0);
    window(0);
    check("R3 cpu rate kept /4", n_cpu, 6);
  endtask

  task automatic t_ext66();
    set_ticks(1, 0, 0, 1, 1);
    power_up(2'b10, 1'b1);
    check("R2 strap_mode ext", strap_mode, 2);
    window(1);
    check("R6 buf66 passes ext", n_buf, 12);
    check("R6 pci ext /2", n_pci, 6);
    check("R6 v66 internal /6", n_v66, 4);
    check("R5 cpu /3 in ext", n_cpu, 8);
    check("R10 ref in ext", n_ref, 24);
  endtask

  task automatic t_test();
    set_ticks(0, 0, 1, 0, 0);
    power_up(2'b01, 1'b0);
    check("R8 no error in test", mode_error, 0);
    window(0);
    check("R7 cpu /2", n_cpu, 12);
    check("R7 v66 /4", n_v66, 6);
    check("R7 buf66 /4", n_buf, 6);
    check("R7 pci /8", n_pci, 3);
    check("R7 ref /1", n_ref, 24);
    check("R7 usb /2", n_usb, 12);
    check("R9 first pci index test", first_pci, 7);
  endtask

  task automatic t_reserved(input logic [1:0] code, input logic fs);
    set_ticks(1, 1, 1, 1, 1);
    power_up(code, fs);
    check("R8 mode_error", mode_error, 1);
    window(0);
    check("R8 all quiet", n_cpu + n_v66 + n_buf + n_pci + n_ref + n_usb, 0);
  endtask

  initial begin
    t_idle();
    t_normal_100();
    t_normal_133();
    t_ignore();
    t_ext66();
    t_test();
    t_reserved(2'b01, 1'b1);
    t_reserved(2'b11, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule